// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps track of loads that were scheduled ahead of stores that come earlier in program order. When such a hoisted load executes, the table notes three things: which register it wrote, the 8-byte block of memory it read, and the value it returned. From then on, every store address is compared in parallel against all live entries. A store that hits a tracked block removes that entry and raises a poison pulse for the register the load wrote, so the register file can mark that register's value as untrustworthy. The table never forwards store data.

Later, a check operation names a register and asks whether its tracked load is still intact. A hit means the hoisted load is still good, and the check also returns the value that was recorded. A miss tells the recovery path to reload. A check may also be issued in a clearing form, which removes the entry after reporting it. The table holds sixteen entries and any entry can hold any register. New loads take the lowest free slot. When no slot is free, a rotating pointer chooses the entry to replace.

Top module: `spec_load_table`

## Requirements
- R1: After reset every entry is empty: `chkHit` is 0, `chkData` is 0, `poisonSet` is all zero, and a check of any register reports a miss.
- R2: An allocation (`allocValid`=1) records `allocReg`, `allocAddr` and `allocData`. A check of that register issued in any later cycle reports a hit and returns `allocData`.
- R3: A store (`storeValid`=1) matches an entry when address bits [63:3] are equal. Bits [2:0] are ignored. A matching entry is invalidated, and bit `poisonSet[reg]` is 1 for exactly the one cycle after the store.
- R4: A store to a different 8-byte block leaves every entry valid and keeps `poisonSet` at zero.
- R5: The response to a check (`chkValid`=1) appears one cycle later. On a hit, `chkHit` is 1 and `chkData` holds the recorded value. On a miss, or in a cycle with no check, `chkHit` is 0 and `chkData` is 0.
- R6: A check with `chkClear`=1 that hits also invalidates the entry. A check with `chkClear`=0 leaves the entry valid.
- R7: An allocation to a register that already has a valid entry overwrites that entry with the new address and data. The old address then no longer matches stores.
- R8: When no entry already tracks the register, an allocation takes the lowest-numbered free entry. When all 16 entries are valid, it replaces the entry selected by a rotating pointer. The pointer starts at entry 0 after reset and advances by one with each replacement.
- R9: When an allocation and a store occur in the same cycle, the store is compared only against the older entries and does not see the new address. The new entry ends valid, and any older entries that match are still poisoned.
- R10: A check sees the table as it stood at the start of its cycle. An allocation, store or clear in the same cycle does not change that check's result.
- R11: A store that matches several entries invalidates all of them and raises all of their poison bits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Hoisted load completes this cycle |
| allocReg | input | 7 | Destination register of the load |
| allocAddr | input | 64 | Byte address the load read |
| allocData | input | 64 | Value the load returned |
| storeValid | input | 1 | A store executes this cycle |
| storeAddr | input | 64 | Byte address of the store |
| chkValid | input | 1 | Check request |
| chkReg | input | 7 | Register being checked |
| chkClear | input | 1 | Invalidate the entry when the check hits |
| chkHit | output | 1 | Registered check result |
| chkData | output | 64 | Recorded value on a hit, zero otherwise |
| poisonSet | output | 128 | One-cycle pulse per register to be poisoned |

## Verification
Store snooping is exercised with four kinds of store address: one in the same 8-byte block as an entry but with different low bits, one in the next block over, the old address of an entry that has since been overwritten, and one address shared by two entries. Together these separate the effect of the address granularity, a stale tag, and matching more than one entry at once. Same-cycle combinations are also driven: a check alongside a store, a check alongside an overwrite, and an allocation alongside a store, with and without an older match. These show whether the snoop and the check read the table before the cycle's updates take effect. A fill-and-overflow sequence mixed with clears shows whether free-slot reuse and the rotating replacement pointer are kept apart.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int unsigned SltEntries = 16;
  localparam int unsigned SltIdxW    = $clog2(SltEntries);

  typedef logic [SltEntries-1:0] entryVec_t;

  // Per-entry strobes from control to datapath
  typedef struct packed {
    entryVec_t writeSel;   // entry written by this cycle's allocation
    entryVec_t killSel;    // entries invalidated (store hit or clearing check)
    entryVec_t poisonSel;  // entries whose register is poisoned
  } tableStrobes_t;
endpackage

// File: rtl/slt_ctrl.sv
module slt_ctrl
  import slt_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          allocValid,
  input  logic          storeValid,
  input  logic          chkValid,
  input  logic          chkClear,
  input  entryVec_t     validVec,
  input  entryVec_t     allocRegEq,
  input  entryVec_t     storeEq,
  input  entryVec_t     chkEq,
  output tableStrobes_t strb
);
  logic [SltIdxW-1:0] rrPtr;
  entryVec_t          allocHitV;
  entryVec_t          firstFree;
  logic               replace;

  always_comb begin
    allocHitV = allocRegEq & validVec;
    firstFree = '0;
    for (int i = SltEntries - 1; i >= 0; i--) begin
      if (!validVec[i]) firstFree = entryVec_t'(1) << i;
    end
    replace       = 1'b0;
    strb.writeSel = '0;
    if (allocValid) begin
      if (|allocHitV) begin
        strb.writeSel = allocHitV;
      end else if (|firstFree) begin
        strb.writeSel = firstFree;
      end else begin
        strb.writeSel = entryVec_t'(1) << rrPtr;
        replace       = 1'b1;
      end
    end
    // Snoop and clear act on the table as it stood at the start of the cycle
    strb.poisonSel = storeValid ? (storeEq & validVec) : '0;
    strb.killSel   = strb.poisonSel |
                     ((chkValid && chkClear) ? (chkEq & validVec) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (replace) begin
      if (rrPtr == SltIdxW'(SltEntries - 1)) rrPtr <= '0;
      else                                   rrPtr <= rrPtr + 1'b1;
    end
  end

  // R8: every allocation selects exactly one entry
  assert_one_slot_R8: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |-> $countones(strb.writeSel) == 1);

  // R8: the replacement pointer moves only on allocations
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !allocValid |=> $stable(rrPtr));
endmodule

// File: rtl/slt_datapath.sv
module slt_datapath
  import slt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned REG_W     = 7,
  parameter int unsigned GRAN_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  storeValid,
  input  logic                  chkValid,
  input  logic [REG_W-1:0]      allocReg,
  input  logic [ADDR_W-1:0]     allocAddr,
  input  logic [DATA_W-1:0]     allocData,
  input  logic [ADDR_W-1:0]     storeAddr,
  input  logic [REG_W-1:0]      chkReg,
  input  tableStrobes_t         strb,
  output entryVec_t             validVec,
  output entryVec_t             allocRegEq,
  output entryVec_t             storeEq,
  output entryVec_t             chkEq,
  output logic                  chkHit,
  output logic [DATA_W-1:0]     chkData,
  output logic [(1<<REG_W)-1:0] poisonSet
);
  localparam int unsigned TagW    = ADDR_W - GRAN_BITS;
  localparam int unsigned NumRegs = 1 << REG_W;

  entryVec_t         validQ;
  logic [REG_W-1:0]  entryReg  [SltEntries];
  logic [TagW-1:0]   entryTag  [SltEntries];
  logic [DATA_W-1:0] entryData [SltEntries];

  logic [DATA_W-1:0]  hitData;
  logic [NumRegs-1:0] poisonNext;

  for (genvar e = 0; e < SltEntries; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (strb.writeSel[e]) begin
        entryReg[e]  <= allocReg;
        entryTag[e]  <= allocAddr[ADDR_W-1:GRAN_BITS];
        entryData[e] <= allocData;
      end
    end
    assign allocRegEq[e] = (entryReg[e] == allocReg);
    assign storeEq[e]    = (entryTag[e] == storeAddr[ADDR_W-1:GRAN_BITS]);
    assign chkEq[e]      = (entryReg[e] == chkReg);
  end

  // The allocation write takes effect after the snoop and clear
  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else       validQ <= (validQ & ~strb.killSel) | strb.writeSel;
  end
  assign validVec = validQ;

  always_comb begin
    hitData    = '0;
    poisonNext = '0;
    for (int i = 0; i < SltEntries; i++) begin
      if (chkEq[i] && validQ[i]) hitData = hitData | entryData[i];
      if (strb.poisonSel[i]) poisonNext[entryReg[i]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkHit    <= 1'b0;
      chkData   <= '0;
      poisonSet <= '0;
    end else begin
      chkHit    <= chkValid && |(chkEq & validQ);
      chkData   <= chkValid ? hitData : '0;
      poisonSet <= poisonNext;
    end
  end

  // R3: a store hitting a live entry produces a poison pulse
  assert_poison_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && |(storeEq & validQ)) |=> (poisonSet != '0));

  // R3: the matched entries are gone after the store
  assert_store_kills_R3: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && !(|strb.writeSel)) |=> ((validQ & $past(storeEq & validQ)) == '0));

  // R4: no store, no poison
  assert_quiet_poison_R4: assert property (@(posedge clk) disable iff (!rstN)
    !storeValid |=> (poisonSet == '0));

  // R5: no check, no response
  assert_chk_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> (!chkHit && chkData == '0));
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned REG_W     = 7,
  parameter int unsigned GRAN_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  allocValid,
  input  logic [REG_W-1:0]      allocReg,
  input  logic [ADDR_W-1:0]     allocAddr,
  input  logic [DATA_W-1:0]     allocData,
  input  logic                  storeValid,
  input  logic [ADDR_W-1:0]     storeAddr,
  input  logic                  chkValid,
  input  logic [REG_W-1:0]      chkReg,
  input  logic                  chkClear,
  output logic                  chkHit,
  output logic [DATA_W-1:0]     chkData,
  output logic [(1<<REG_W)-1:0] poisonSet
);
  tableStrobes_t strb;
  entryVec_t     validVec, allocRegEq, storeEq, chkEq;

  slt_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .storeValid (storeValid),
    .chkValid   (chkValid),
    .chkClear   (chkClear),
    .validVec   (validVec),
    .allocRegEq (allocRegEq),
    .storeEq    (storeEq),
    .chkEq      (chkEq),
    .strb       (strb)
  );

  slt_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REG_W     (REG_W),
    .GRAN_BITS (GRAN_BITS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .storeValid (storeValid),
    .chkValid   (chkValid),
    .allocReg   (allocReg),
    .allocAddr  (allocAddr),
    .allocData  (allocData),
    .storeAddr  (storeAddr),
    .chkReg     (chkReg),
    .strb       (strb),
    .validVec   (validVec),
    .allocRegEq (allocRegEq),
    .storeEq    (storeEq),
    .chkEq      (chkEq),
    .chkHit     (chkHit),
    .chkData    (chkData),
    .poisonSet  (poisonSet)
  );
endmodule

// File: tb/spec_load_table_tb.sv
`timescale 1ns/1ps
module spec_load_table_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         allocValid, storeValid, chkValid, chkClear;
  logic [6:0]   allocReg, chkReg;
  logic [63:0]  allocAddr, allocData, storeAddr;
  logic         chkHit;
  logic [63:0]  chkData;
  logic [127:0] poisonSet;

  int passCnt = 0;
  int totalCnt = 0;

  always #2 clk = ~clk; // 250 MHz

  spec_load_table dut_i (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocReg(allocReg), .allocAddr(allocAddr), .allocData(allocData),
    .storeValid(storeValid), .storeAddr(storeAddr),
    .chkValid(chkValid), .chkReg(chkReg), .chkClear(chkClear),
    .chkHit(chkHit), .chkData(chkData), .poisonSet(poisonSet)
  );

  typedef struct packed {
    logic         aV;   logic [6:0] aReg; logic [63:0] aAddr; logic [63:0] aData;
    logic         sV;   logic [63:0] sAddr;
    logic         cV;   logic [6:0] cReg; logic cClr;
    logic         eHit; logic [63:0] eData; logic [127:0] ePois;
    logic [7:0]   req;
  } vec_t;

  function automatic vec_t mk(logic aV, logic [6:0] aReg, logic [63:0] aAddr, logic [63:0] aData,
                              logic sV, logic [63:0] sAddr, logic cV, logic [6:0] cReg, logic cClr,
                              logic eHit, logic [63:0] eData, logic [127:0] ePois, logic [7:0] req);
    mk = '{aV, aReg, aAddr, aData, sV, sAddr, cV, cReg, cClr, eHit, eData, ePois, req};
  endfunction

  localparam int NV = 19;
  localparam logic [127:0] P0 = '0;
  localparam vec_t VECS [NV] = '{
    mk(1, 5, 64'h1000, 64'hAAAA, 0, 0,        0, 0, 0,  0, 0,        P0, 2),  // R2 alloc r5
    mk(0, 0, 0, 0,               0, 0,        1, 5, 0,  1, 64'hAAAA, P0, 5),  // R5 hit + data
    mk(0, 0, 0, 0,               1, 64'h1008, 1, 5, 0,  1, 64'hAAAA, P0, 4),  // R4 next block
    mk(0, 0, 0, 0,               1, 64'h1007, 1, 5, 0,  1, 64'hAAAA, 128'(1) << 5, 3), // R3 + R10
    mk(0, 0, 0, 0,               0, 0,        1, 5, 0,  0, 0,        P0, 3),  // R3 entry gone
    mk(1, 9, 64'h2000, 64'h1111, 0, 0,        0, 0, 0,  0, 0,        P0, 2),
    mk(1, 9, 64'h3000, 64'h2222, 0, 0,        1, 9, 0,  1, 64'h1111, P0, 10), // R10 + R7 overwrite
    mk(0, 0, 0, 0,               1, 64'h2000, 1, 9, 0,  1, 64'h2222, P0, 7),  // R7 old addr stale
    mk(0, 0, 0, 0,               0, 0,        1, 9, 1,  1, 64'h2222, P0, 6),  // R6 clearing check
    mk(0, 0, 0, 0,               0, 0,        1, 9, 0,  0, 0,        P0, 6),  // R6 cleared
    mk(1, 12, 64'h4000, 64'h33,  0, 0,        0, 0, 0,  0, 0,        P0, 2),
    mk(0, 0, 0, 0,               0, 0,        1, 12, 0, 1, 64'h33,   P0, 6),  // R6 plain check
    mk(0, 0, 0, 0,               0, 0,        1, 12, 0, 1, 64'h33,   P0, 6),  // R6 still there
    mk(1, 14, 64'h4000, 64'h44,  0, 0,        0, 0, 0,  0, 0,        P0, 2),
    mk(0, 0, 0, 0,               1, 64'h4004, 1, 14, 0, 1, 64'h44,
       (128'(1) << 12) | (128'(1) << 14), 11),                                // R11 two matches
    mk(1, 12, 64'h5000, 64'h55,  1, 64'h5000, 1, 14, 0, 0, 0,        P0, 9),  // R9 store misses new
    mk(0, 0, 0, 0,               0, 0,        1, 12, 0, 1, 64'h55,   P0, 9),  // R9 new entry live
    mk(1, 12, 64'h5000, 64'h66,  1, 64'h5003, 0, 0, 0,  0, 0,        128'(1) << 12, 9), // R9 older poisoned
    mk(0, 0, 0, 0,               0, 0,        1, 12, 0, 1, 64'h66,   P0, 9)   // R9 overwrite survives
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic idleInputs();
    allocValid = 0; allocReg = 0; allocAddr = 0; allocData = 0;
    storeValid = 0; storeAddr = 0; chkValid = 0; chkReg = 0; chkClear = 0;
  endtask

  // Apply one cycle of stimulus, return just after the capturing edge
  task automatic drive(input vec_t v);
    @(negedge clk);
    allocValid = v.aV; allocReg = v.aReg; allocAddr = v.aAddr; allocData = v.aData;
    storeValid = v.sV; storeAddr = v.sAddr;
    chkValid = v.cV; chkReg = v.cReg; chkClear = v.cClr;
    @(posedge clk);
    #1;
    idleInputs();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    idleInputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic expectChk(input logic [6:0] r, input logic clr, input logic eHit,
                           input logic [63:0] eData, input string req);
    drive(mk(0, 0, 0, 0, 0, 0, 1, r, clr, 0, 0, P0, 0));
    check(chkHit == eHit, req, 128'(chkHit), 128'(eHit));
    check(chkData == eData, req, 128'(chkData), 128'(eData));
  endtask

  task automatic doAlloc(input logic [6:0] r, input logic [63:0] a, input logic [63:0] d);
    drive(mk(1, r, a, d, 0, 0, 0, 0, 0, 0, 0, P0, 0));
  endtask

  initial begin
    rstN = 0;
    idleInputs();
    doReset();
    // R1: outputs quiet after reset, empty table
    @(negedge clk);
    check(chkHit == 0, "R1", 128'(chkHit), 0);
    check(chkData == 0, "R1", 128'(chkData), 0);
    check(poisonSet == 0, "R1", poisonSet, 0);
    expectChk(0, 0, 0, 0, "R1");

    for (int i = 0; i < NV; i++) begin
      string tag;
      drive(VECS[i]);
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      check(chkHit == VECS[i].eHit, tag, 128'(chkHit), 128'(VECS[i].eHit));
      check(chkData == VECS[i].eData, tag, 128'(chkData), 128'(VECS[i].eData));
      check(poisonSet == VECS[i].ePois, tag, poisonSet, VECS[i].ePois);
    end
    // R3: poison is a single-cycle pulse
    @(negedge clk);
    check(poisonSet == 0, "R3 pulse", poisonSet, 0);

    // R1: reset empties a populated table (r12 was live)
    doReset();
    expectChk(12, 0, 0, 0, "R1");

    // R8: fill, then rotating replacement and free-slot reuse
    for (int r = 0; r < 16; r++) doAlloc(7'(r), 64'(r * 8), 64'(100 + r));
    doAlloc(20, 64'h800, 64'h20);
    expectChk(0, 0, 0, 0, "R8 victim entry0");
    expectChk(1, 0, 1, 101, "R8");
    expectChk(20, 0, 1, 64'h20, "R8");
    doAlloc(21, 64'h900, 64'h21);
    expectChk(1, 0, 0, 0, "R8 victim entry1");
    expectChk(2, 0, 1, 102, "R8");
    expectChk(7, 1, 1, 107, "R8 clear");
    doAlloc(22, 64'hA00, 64'h22);
    expectChk(2, 0, 1, 102, "R8 free slot used");
    expectChk(3, 0, 1, 103, "R8");
    expectChk(22, 0, 1, 64'h22, "R8");
    doAlloc(23, 64'hB00, 64'h23);
    expectChk(2, 0, 0, 0, "R8 victim entry2");
    expectChk(3, 0, 1, 103, "R8");

    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    #400000;
    totalCnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule